// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 32 interrupt request lines for one processor. Each line can be active-high or active-low, and each can be edge-triggered or level-triggered. A request that becomes active sets a bit in a status register. Software clears a status bit by writing 1 to it. An enable register masks the status bits, and the masked result can be read directly.

Each line is also classed as normal or critical. The block drives one processor output for normal interrupts and another for critical ones. Among the enabled, pending normal interrupts, a priority resolver picks one winner. A register bit sets which end of the status word has the highest priority. The index of the winner is added, scaled by four, to a word-aligned base address. The result is the address of the handler vector.

Registers are read and written over a single-cycle synchronous bus. Writes take effect on the next clock edge. Read data is combinational from the registered state.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, every register reads zero. Both interrupt outputs are low and `vec_addr` is zero.
- R2: The register word addresses are: 0 status, 1 enable, 2 masked status, 3 critical select, 4 polarity invert, 5 trigger select, 6 vector config, 7 vector. In every per-interrupt register, interrupt i sits at data bit 31-i, so bit 31 (the MSB) holds interrupt 0.
- R3: The polarity invert bit decides which input level is active: 1 means active-low and 0 means active-high. The trigger bit decides how the line is sensed: 1 means edge and 0 means level. A level line that is active sets its status bit one clock later.
- R4: For a level line, a write of 1 to its status bit does not clear the bit while the input is still active. The same write clears the bit once the input has gone inactive.
- R5: For an edge line, the status bit is set when the input changes from inactive to active. A write of 1 clears the bit. A write of 0 leaves the bit unchanged.
- R6: The masked status register reads as status AND enable. Writes to the masked status register have no effect.
- R7: `irq_norm` is the OR of the masked status bits whose critical select bit is 0. `irq_crit` is the OR of the masked status bits whose critical select bit is 1. Each output lags the status by one register stage.
- R8: Bit 0 of the vector config register is the priority-ordering bit. When it is 0, interrupt 31 has the highest priority. When it is 1, interrupt 0 has the highest priority. Priority falls one step per index toward the other end of the word.
- R9: The vector equals the base plus 4 times the index of the highest-priority interrupt that is pending, enabled and normal. Critical interrupts take no part in the selection. The vector is zero when no such interrupt exists. It appears on `vec_addr` and at address 7.
- R10: The vector config register is write-only and reads zero. Its bits [31:2] hold the base address, and the two low address bits are always zero. Bit 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_in | input | 32 | Interrupt request lines, index = interrupt number |
| irq_norm | output | 1 | Normal interrupt to the processor |
| irq_crit | output | 1 | Critical interrupt to the processor |
| vec_addr | output | 32 | Handler vector address |

## Verification
Some rules hold on every clock cycle, so the bound assertions check them continuously:
- the masked status read equals status AND enable;
- a level line that is active holds its status bit set against any clear;
- both outputs track the status from one cycle earlier;
- the vector is zero and word-aligned when no normal interrupt is pending;
- the vector config register reads zero.

Other behaviour only shows up in the bench scenarios:
- the big-endian bit placement;
- edge capture and write-1-to-clear;
- the polarity invert;
- the priority direction;
- the exact vector arithmetic against a chosen base;
- the removal of critical lines from the selection.

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] irq_in,
  output logic        irq_norm,
  output logic        irq_crit,
  output logic [31:0] vec_addr
);
  localparam logic [2:0] A_STAT = 3'd0, A_ENAB = 3'd1, A_MSTAT = 3'd2, A_CRIT = 3'd3,
                         A_INV  = 3'd4, A_TRIG = 3'd5, A_VCFG  = 3'd6, A_VEC  = 3'd7;

  function automatic logic [31:0] swap(input logic [31:0] v);
    for (int i = 0; i < 32; i++) swap[i] = v[31-i];
  endfunction

  logic [31:0] stat, enab, crit, inv, trig, act, act_q;
  logic [31:0] setv, clr, pend;
  logic [29:0] base_q;
  logic        order_q;
  logic [4:0]  idx;
  logic        hit;

  assign act  = irq_in ^ inv;
  assign setv = (trig & act & ~act_q) | (~trig & act);
  assign clr  = (reg_we && reg_addr == A_STAT) ? swap(reg_wdata) : 32'd0;
  assign pend = stat & enab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0; enab <= '0; crit <= '0; inv <= '0; trig <= '0; act_q <= '0;
      base_q <= '0; order_q <= 1'b0; irq_norm <= 1'b0; irq_crit <= 1'b0;
    end else begin
      act_q    <= act;
      stat     <= (stat & ~clr) | setv;
      irq_norm <= |(pend & ~crit);
      irq_crit <= |(pend & crit);
      if (reg_we) begin
        case (reg_addr)
          A_ENAB: enab <= swap(reg_wdata);
          A_CRIT: crit <= swap(reg_wdata);
          A_INV:  inv  <= swap(reg_wdata);
          A_TRIG: trig <= swap(reg_wdata);
          A_VCFG: begin base_q <= reg_wdata[31:2]; order_q <= reg_wdata[0]; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (order_q) begin
        if (pend[31-i] && !crit[31-i]) begin idx = 5'(31 - i); hit = 1'b1; end
      end else begin
        if (pend[i] && !crit[i]) begin idx = 5'(i); hit = 1'b1; end
      end
    end
  end

  assign vec_addr = hit ? ({base_q, 2'b00} + {25'd0, idx, 2'b00}) : 32'd0;

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = swap(stat);
      A_ENAB:  reg_rdata = swap(enab);
      A_MSTAT: reg_rdata = swap(pend);
      A_CRIT:  reg_rdata = swap(crit);
      A_INV:   reg_rdata = swap(inv);
      A_TRIG:  reg_rdata = swap(trig);
      A_VCFG:  reg_rdata = 32'd0;
      A_VEC:   reg_rdata = vec_addr;
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic [31:0] stat,
  input logic [31:0] enab,
  input logic [31:0] crit,
  input logic [31:0] trig,
  input logic [31:0] act,
  input logic        irq_norm,
  input logic        irq_crit,
  input logic [31:0] vec_addr
);
  function automatic logic [31:0] swap(input logic [31:0] v);
    for (int i = 0; i < 32; i++) swap[i] = v[31-i];
  endfunction

  logic        armed;
  logic [31:0] lvl_act, nrm, crt;
  assign lvl_act = ~trig & act;
  assign nrm     = stat & enab & ~crit;
  assign crt     = stat & enab & crit;

  always_ff @(posedge clk) armed <= rst_n;

  assert_masked_view_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd2) |-> (reg_rdata == swap(stat & enab)));

  assert_level_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((stat & $past(lvl_act)) == $past(lvl_act)));

  assert_norm_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq_norm == $past(|nrm)));

  assert_crit_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (irq_crit == $past(|crt)));

  assert_vec_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (nrm == 32'd0) |-> (vec_addr == 32'd0));

  assert_vec_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr[1:0] == 2'b00);

  assert_vcfg_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 3'd6) |-> (reg_rdata == 32'd0));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .stat(stat), .enab(enab), .crit(crit), .trig(trig), .act(act),
  .irq_norm(irq_norm), .irq_crit(irq_crit), .vec_addr(vec_addr)
);

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [31:0] irq_in = 32'd0;
  logic        irq_norm, irq_crit;
  logic [31:0] vec_addr;

  always #4 clk = ~clk;

  irq_vector_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in),
    .irq_norm(irq_norm), .irq_crit(irq_crit), .vec_addr(vec_addr)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  item_t cur;
  logic  mon_en = 1'b0;
  logic [31:0] got;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [31:0] b(input int i);
    return 32'h8000_0000 >> i;
  endfunction

  always @(negedge clk) begin
    if (mon_en && q.size() > 0) begin
      cur = q.pop_front();
      case (cur.kind)
        0: got = reg_rdata;
        1: got = {31'd0, irq_norm};
        2: got = {31'd0, irq_crit};
        default: got = vec_addr;
      endcase
      n_chk++;
      if (got !== cur.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", cur.tag, got, cur.exp);
      end
    end
  end

  task automatic chk(input int kind, input logic [2:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    mon_en = 1'b1;
    @(negedge clk); #1;
    mon_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    for (int a = 0; a < 8; a++) chk(0, 3'(a), 32'd0, "R1 register reset");
    chk(1, 0, 0, "R1 irq_norm reset");
    chk(2, 0, 0, "R1 irq_crit reset");
    chk(3, 0, 0, "R1 vec reset");

    wr(3'd1, 32'hFFFF_FFFF);
    irq_in[5] = 1'b1;
    idle(2);
    chk(0, 3'd0, b(5), "R2 R3 level status bit placement");
    chk(0, 3'd2, b(5), "R6 masked view");
    chk(1, 0, 1, "R7 irq_norm asserted");
    chk(3, 0, 32'd20, "R9 vector for index 5 base 0");

    wr(3'd0, b(5));
    chk(0, 3'd0, b(5), "R4 clear blocked while active");
    irq_in[5] = 1'b0;
    idle(1);
    wr(3'd0, b(5));
    chk(0, 3'd0, 32'd0, "R4 clear after release");

    wr(3'd5, b(7));
    irq_in[7] = 1'b1;
    idle(1);
    irq_in[7] = 1'b0;
    idle(1);
    chk(0, 3'd0, b(7), "R5 edge captured");
    wr(3'd0, 32'd0);
    chk(0, 3'd0, b(7), "R5 write zero keeps bit");
    wr(3'd0, b(7));
    chk(0, 3'd0, 32'd0, "R5 write one clears");

    wr(3'd4, b(9));
    idle(1);
    chk(0, 3'd0, b(9), "R3 active-low level sets");
    irq_in[9] = 1'b1;
    idle(1);
    wr(3'd0, b(9));
    chk(0, 3'd0, 32'd0, "R3 inactive-low clears");

    wr(3'd1, b(3) | b(10));
    irq_in[3] = 1'b1; irq_in[10] = 1'b1; irq_in[20] = 1'b1;
    idle(2);
    chk(0, 3'd0, b(3) | b(10) | b(20), "R3 three levels pending");
    chk(0, 3'd2, b(3) | b(10), "R6 masked excludes disabled");
    wr(3'd2, 32'hFFFF_FFFF);
    chk(0, 3'd2, b(3) | b(10), "R6 write to masked ignored");

    wr(3'd6, 32'h0000_1000);
    chk(3, 0, 32'h1028, "R8 order0 high index wins");
    wr(3'd6, 32'h0000_1003);
    chk(3, 0, 32'h100C, "R8 order1 low index wins");
    chk(0, 3'd6, 32'd0, "R10 vector config reads zero");
    chk(0, 3'd7, 32'h100C, "R9 vector readable at address 7");

    wr(3'd3, b(3));
    chk(3, 0, 32'h1028, "R9 critical excluded");
    chk(2, 0, 1, "R7 irq_crit asserted");
    chk(1, 0, 1, "R7 irq_norm still asserted");
    wr(3'd3, b(3) | b(10));
    chk(3, 0, 32'd0, "R9 no normal pending");
    chk(1, 0, 0, "R7 irq_norm drops");
    chk(2, 0, 1, "R7 irq_crit stays");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule